// File: doc/BRIEF.md
# SPI NAND Command Frame Engine

This block drives one serial NAND transaction at a time onto SPI pins. A host presents a request that holds an opcode, an address of up to `ADDR_MAX` bytes, a count of address bytes, a count of dummy clocks, a direction bit, a data byte count and a four-lane flag. The engine pulls chip-select low and shifts out the phases in a fixed order: opcode, address, dummy, data. A phase whose count is zero is skipped. The opcode, address and dummy phases always use lane IO0. The data phase uses either one lane or all four lanes, so the same engine handles register access (one address byte, one data byte), identification reads, cache reads with a two-byte column address and eight dummy clocks, row commands with three address bytes and no data, and bare opcode frames.

The serial clock runs in mode 0. It idles low, and the device samples on the rising edge. Outgoing bits change only on falling edges, and read bits are captured on rising edges. Write bytes arrive on a valid/ready stream. Read bytes leave on a valid/ready stream. At a byte boundary the serial clock pauses for as long as the write stream is empty or a read byte has not yet been taken. After the last data clock, chip-select rises, a one-cycle `done` pulse follows, and chip-select stays high for at least one serial clock period before the next request is accepted.

The phase sequencer uses these states: `ST_IDLE` (awaiting a request), `ST_OPC` (opcode bits), `ST_ADR` (address bits), `ST_DMY` (dummy clocks), `ST_DAT` (data beats), `ST_TAIL` (hold before deselect), `ST_RISE` (chip-select just raised), `ST_ACK` (done pulse) and `ST_GAP` (deselect time). The transitions are as follows. `ST_IDLE`→`ST_OPC` happens on request accept. At the falling edge of each phase's last clock, the engine moves to the next phase whose count is non-zero, or to `ST_TAIL`. `ST_TAIL`→`ST_RISE` happens on the next clock tick. `ST_RISE`→`ST_ACK`→`ST_GAP` take one cycle each. `ST_GAP`→`ST_IDLE` happens after two ticks.

Top module: `spi_nand_frame_engine`

## Requirements
- R1: `req_ready` is high only in the idle state; a request accepted at a clock edge drives `spi_cs_n` low at that edge, and `req_ready` is low from then until the frame completes.
- R2: `spi_sck` is low whenever `spi_cs_n` is high, and every rising edge of `spi_sck` falls inside a selected frame (mode 0).
- R3: The first 8 serial clocks carry `req_opcode` on IO0, MSB first, with only IO0 enabled (`spi_io_oe` = 4'b0001).
- R4: The next 8×`req_addr_bytes` clocks carry the low `req_addr_bytes` bytes of `req_addr`, most significant byte first and MSB first within each byte, on IO0 with `spi_io_oe` = 4'b0001; a count of 0 skips the phase.
- R5: The next `req_dummy` clocks drive IO0 low with `spi_io_oe` = 4'b0001; a count of 0 skips the phase.
- R6: In one-lane data mode (`req_quad`=0), a write sends each byte MSB first on IO0 (`spi_io_oe` = 4'b0001), and a read captures each byte MSB first from IO1 on rising edges, with `spi_io_oe` = 4'b0000.
- R7: In four-lane data mode (`req_quad`=1), each byte takes two clocks with the high nibble first and IO3 carrying the nibble MSB; writes enable all four lanes (4'b1111), and reads release all lanes (4'b0000) and capture IO[3:0].
- R8: A frame has exactly 8 + 8×addr_bytes + dummy + len×(quad ? 2 : 8) serial clocks, in the order opcode, address, dummy, data; a length of 0 gives no data phase.
- R9: `done` is high for exactly one cycle, in the cycle after `spi_cs_n` rises; `spi_cs_n` then stays high for more than 2×`SCK_DIV` cycles before the next frame.
- R10: The serial clock pauses at a byte boundary while a write byte is not yet available or a read byte has not been taken; `rd_valid` and `rd_data` hold until `rd_ready`, and a write frame consumes exactly `req_len` bytes.
- R11: During reset `spi_cs_n`=1, `spi_sck`=0, `spi_io_oe`=0, `done`=0 and `rd_valid`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted when high with `req_valid` |
| req_opcode | input | 8 | Command opcode |
| req_addr | input | 8×ADDR_MAX | Address, right-aligned |
| req_addr_bytes | input | clog2(ADDR_MAX+1) | Number of address bytes sent |
| req_dummy | input | DUMMY_W | Number of dummy clocks |
| req_read | input | 1 | 1 = data phase reads, 0 = writes |
| req_len | input | LEN_W | Number of data bytes |
| req_quad | input | 1 | Four-lane data phase |
| wr_data | input | 8 | Write byte |
| wr_valid | input | 1 | Write byte present |
| wr_ready | output | 1 | Engine takes the write byte |
| rd_data | output | 8 | Read byte |
| rd_valid | output | 1 | Read byte present |
| rd_ready | input | 1 | Host takes the read byte |
| done | output | 1 | One-cycle frame-complete pulse |
| spi_cs_n | output | 1 | Chip-select, active low |
| spi_sck | output | 1 | Serial clock |
| spi_io_o | output | 4 | IO lane output values |
| spi_io_oe | output | 4 | IO lane output enables |
| spi_io_i | input | 4 | IO lane input values |

## Verification
The assertions assume that `req_addr_bytes` never exceeds `ADDR_MAX` and that the request fields stay stable while `req_valid` is high. They also assume that `rd_ready` is a free host choice. With that freedom, a held read byte has to stay unchanged until it is taken. The stimulus draws address counts from 0 to 3 and dummy counts from 0 to 15. It holds each request constant until it is accepted. It toggles `wr_valid` and `rd_ready` at random to force stalls at byte boundaries. A bench device model drives IO1 or IO[3:0] from a known byte sequence only during the expected data clocks.

// File: rtl/spinand_frame_pkg.sv
`timescale 1ns/1ps
package spinand_frame_pkg;
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_OPC,
        ST_ADR,
        ST_DMY,
        ST_DAT,
        ST_TAIL,
        ST_RISE,
        ST_ACK,
        ST_GAP
    } snfe_state_e;
endpackage

// File: rtl/snfe_tick.sv
`timescale 1ns/1ps
// Half-period tick generator for the serial clock.
module snfe_tick #(
    parameter int DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

    logic [CW-1:0] cnt;

    assign tick = en && (cnt == CW'(DIV - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!en || tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/snfe_lane_shift.sv
`timescale 1ns/1ps
// Data byte shifter: one bit per step (one lane) or one nibble per step (four lanes).
module snfe_lane_shift (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load,
    input  logic [7:0] load_val,
    input  logic       step,
    input  logic       quad,
    input  logic [3:0] fill,
    output logic [7:0] q,
    output logic [7:0] nxt
);
    assign nxt = quad ? {q[3:0], fill} : {q[6:0], fill[0]};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else if (load) begin
            q <= load_val;
        end else if (step) begin
            q <= nxt;
        end
    end
endmodule

// File: rtl/spi_nand_frame_engine.sv
`timescale 1ns/1ps
module spi_nand_frame_engine
    import spinand_frame_pkg::*;
#(
    parameter int SCK_DIV  = 2,
    parameter int ADDR_MAX = 3,
    parameter int DUMMY_W  = 4,
    parameter int LEN_W    = 12
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          req_valid,
    output logic                          req_ready,
    input  logic [7:0]                    req_opcode,
    input  logic [8*ADDR_MAX-1:0]         req_addr,
    input  logic [$clog2(ADDR_MAX+1)-1:0] req_addr_bytes,
    input  logic [DUMMY_W-1:0]            req_dummy,
    input  logic                          req_read,
    input  logic [LEN_W-1:0]              req_len,
    input  logic                          req_quad,
    input  logic [7:0]                    wr_data,
    input  logic                          wr_valid,
    output logic                          wr_ready,
    output logic [7:0]                    rd_data,
    output logic                          rd_valid,
    input  logic                          rd_ready,
    output logic                          done,
    output logic                          spi_cs_n,
    output logic                          spi_sck,
    output logic [3:0]                    spi_io_o,
    output logic [3:0]                    spi_io_oe,
    input  logic [3:0]                    spi_io_i
);
    localparam int ADDR_W  = 8 * ADDR_MAX;
    localparam int AB_W    = $clog2(ADDR_MAX + 1);
    localparam int DMY_MAX = (1 << DUMMY_W) - 1;
    localparam int PH_MAX  = (ADDR_W > DMY_MAX) ? ADDR_W : DMY_MAX;
    localparam int CNT_W   = $clog2(PH_MAX + 1);

    snfe_state_e state, tgt;
    snfe_state_e after_opc, after_adr, after_dmy;

    logic              cs_q, sck_q;
    logic [ADDR_W-1:0] sh, lat_addr, addr_aligned;
    logic [CNT_W-1:0]  ph_cnt;
    logic [AB_W-1:0]   lat_ab;
    logic [DUMMY_W-1:0] lat_dm;
    logic              lat_rd, lat_quad, loaded;
    logic [LEN_W-1:0]  lat_len, bytes_left;
    logic [2:0]        beat, beat_last;
    logic [7:0]        rd_q, lane_q, lane_nxt;
    logic              rd_v_q;
    logic              tick, tick_en, stall, shifting, rise, fall, adv;
    logic              wr_fire, lane_step, rd_push;
    logic [3:0]        lane_fill;

    // ---------------- sub-blocks ----------------
    snfe_tick #(.DIV(SCK_DIV)) u_tick (
        .clk  (clk),
        .rst_n(rst_n),
        .en   (tick_en),
        .tick (tick)
    );

    snfe_lane_shift u_lane (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (wr_fire),
        .load_val(wr_data),
        .step    (lane_step),
        .quad    (lat_quad),
        .fill    (lane_fill),
        .q       (lane_q),
        .nxt     (lane_nxt)
    );

    // ---------------- phase decisions ----------------
    assign addr_aligned = lat_addr << (ADDR_W - 8 * int'(lat_ab));
    assign beat_last    = lat_quad ? 3'd1 : 3'd7;
    assign lane_fill    = lat_rd ? (lat_quad ? spi_io_i : {3'b000, spi_io_i[1]}) : 4'b0000;

    always_comb begin
        after_dmy = (lat_len != '0) ? ST_DAT : ST_TAIL;
        after_adr = (lat_dm != '0) ? ST_DMY : after_dmy;
        after_opc = (lat_ab != '0) ? ST_ADR : after_adr;

        shifting = (state == ST_OPC) || (state == ST_ADR) ||
                   (state == ST_DMY) || (state == ST_DAT);
        stall    = (state == ST_DAT) && !sck_q && (beat == 3'd0) &&
                   (lat_rd ? rd_v_q : !loaded);
        tick_en  = (shifting || (state == ST_TAIL) || (state == ST_GAP)) && !stall;
        rise     = tick && shifting && !sck_q;
        fall     = tick && shifting && sck_q;

        adv = 1'b0;
        tgt = state;
        if (fall) begin
            case (state)
                ST_OPC: if (ph_cnt == CNT_W'(1)) begin adv = 1'b1; tgt = after_opc; end
                ST_ADR: if (ph_cnt == CNT_W'(1)) begin adv = 1'b1; tgt = after_adr; end
                ST_DMY: if (ph_cnt == CNT_W'(1)) begin adv = 1'b1; tgt = after_dmy; end
                ST_DAT: if (beat == beat_last && bytes_left == LEN_W'(1)) begin
                            adv = 1'b1;
                            tgt = ST_TAIL;
                        end
                default: ;
            endcase
        end

        wr_fire   = wr_valid && wr_ready;
        lane_step = (state == ST_DAT) && ((rise && lat_rd) || (fall && !lat_rd));
        rd_push   = rise && (state == ST_DAT) && lat_rd && (beat == beat_last);
    end

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            cs_q       <= 1'b1;
            sck_q      <= 1'b0;
            sh         <= '0;
            ph_cnt     <= '0;
            lat_addr   <= '0;
            lat_ab     <= '0;
            lat_dm     <= '0;
            lat_rd     <= 1'b0;
            lat_quad   <= 1'b0;
            lat_len    <= '0;
            bytes_left <= '0;
            beat       <= '0;
            loaded     <= 1'b0;
            rd_q       <= '0;
            rd_v_q     <= 1'b0;
        end else begin
            if (rd_push) begin
                rd_q   <= lane_nxt;
                rd_v_q <= 1'b1;
            end else if (rd_ready) begin
                rd_v_q <= 1'b0;
            end

            if (rise) sck_q <= 1'b1;
            if (fall) sck_q <= 1'b0;

            unique case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        lat_addr <= req_addr;
                        lat_ab   <= req_addr_bytes;
                        lat_dm   <= req_dummy;
                        lat_rd   <= req_read;
                        lat_quad <= req_quad;
                        lat_len  <= req_len;
                        sh       <= ADDR_W'(req_opcode) << (ADDR_W - 8);
                        ph_cnt   <= CNT_W'(8);
                        cs_q     <= 1'b0;
                        state    <= ST_OPC;
                    end
                end
                ST_OPC, ST_ADR, ST_DMY: begin
                    if (fall) begin
                        if (adv) begin
                            state <= tgt;
                            case (tgt)
                                ST_ADR: begin
                                    sh     <= addr_aligned;
                                    ph_cnt <= CNT_W'({lat_ab, 3'b000});
                                end
                                ST_DMY: ph_cnt <= CNT_W'(lat_dm);
                                ST_DAT: begin
                                    bytes_left <= lat_len;
                                    beat       <= '0;
                                    loaded     <= 1'b0;
                                end
                                default: ;
                            endcase
                        end else begin
                            sh     <= sh << 1;
                            ph_cnt <= ph_cnt - 1'b1;
                        end
                    end
                end
                ST_DAT: begin
                    if (wr_fire) loaded <= 1'b1;
                    if (fall) begin
                        if (beat == beat_last) begin
                            beat       <= '0;
                            loaded     <= 1'b0;
                            bytes_left <= bytes_left - 1'b1;
                        end else begin
                            beat <= beat + 1'b1;
                        end
                        if (adv) state <= ST_TAIL;
                    end
                end
                ST_TAIL: begin
                    if (tick) begin
                        cs_q  <= 1'b1;
                        state <= ST_RISE;
                    end
                end
                ST_RISE: state <= ST_ACK;
                ST_ACK: begin
                    state  <= ST_GAP;
                    ph_cnt <= CNT_W'(2);
                end
                ST_GAP: begin
                    if (tick) begin
                        if (ph_cnt == CNT_W'(1)) state <= ST_IDLE;
                        else ph_cnt <= ph_cnt - 1'b1;
                    end
                end
            endcase
        end
    end

    // ---------------- outputs ----------------
    always_comb begin
        req_ready = 1'b0;
        wr_ready  = 1'b0;
        done      = 1'b0;
        spi_io_o  = 4'b0000;
        spi_io_oe = 4'b0000;
        unique case (state)
            ST_IDLE: req_ready = 1'b1;
            ST_OPC, ST_ADR: begin
                spi_io_oe = 4'b0001;
                spi_io_o  = {3'b000, sh[ADDR_W-1]};
            end
            ST_DMY: spi_io_oe = 4'b0001;
            ST_DAT: begin
                wr_ready = !lat_rd && !loaded;
                if (!lat_rd) begin
                    if (lat_quad) begin
                        spi_io_oe = 4'b1111;
                        spi_io_o  = lane_q[7:4];
                    end else begin
                        spi_io_oe = 4'b0001;
                        spi_io_o  = {3'b000, lane_q[7]};
                    end
                end
            end
            ST_TAIL: spi_io_oe = 4'b0001;
            ST_RISE: ;
            ST_ACK:  done = 1'b1;
            ST_GAP:  ;
        endcase
        spi_cs_n = cs_q;
        spi_sck  = sck_q;
        rd_data  = rd_q;
        rd_valid = rd_v_q;
    end
endmodule

// File: rtl/snfe_checker.sv
`timescale 1ns/1ps
module snfe_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       spi_cs_n,
    input logic       spi_sck,
    input logic [3:0] spi_io_oe,
    input logic       done,
    input logic       req_ready,
    input logic       rd_valid,
    input logic       rd_ready,
    input logic [7:0] rd_data
);
    a_r2_sck_low_deselected: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n |-> !spi_sck);

    a_r1_ready_deselected: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> spi_cs_n);

    a_r9_done_after_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(spi_cs_n) |=> done);

    a_r9_done_while_high: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> spi_cs_n);

    a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r7_lane_enables: assert property (@(posedge clk) disable iff (!rst_n)
        (spi_io_oe == 4'b0000) || (spi_io_oe == 4'b0001) || (spi_io_oe == 4'b1111));

    a_r10_read_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));
endmodule

bind spi_nand_frame_engine snfe_checker chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .spi_cs_n (spi_cs_n),
    .spi_sck  (spi_sck),
    .spi_io_oe(spi_io_oe),
    .done     (done),
    .req_ready(req_ready),
    .rd_valid (rd_valid),
    .rd_ready (rd_ready),
    .rd_data  (rd_data)
);

// File: tb/spi_nand_frame_engine_tb_top.sv
`timescale 1ns/1ps
module spi_nand_frame_engine_tb_top;
    localparam int SCK_DIV = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_ready;
    logic [7:0]  req_opcode = '0;
    logic [23:0] req_addr = '0;
    logic [1:0]  req_addr_bytes = '0;
    logic [3:0]  req_dummy = '0;
    logic        req_read = 1'b0, req_quad = 1'b0;
    logic [11:0] req_len = '0;
    logic [7:0]  wr_data = '0;
    logic        wr_valid = 1'b0, wr_ready;
    logic [7:0]  rd_data;
    logic        rd_valid, rd_ready = 1'b0;
    logic        done, spi_cs_n, spi_sck;
    logic [3:0]  spi_io_o, spi_io_oe, spi_io_i;

    always #2.5 clk = ~clk;

    spi_nand_frame_engine #(.SCK_DIV(SCK_DIV)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_opcode(req_opcode), .req_addr(req_addr),
        .req_addr_bytes(req_addr_bytes), .req_dummy(req_dummy),
        .req_read(req_read), .req_len(req_len), .req_quad(req_quad),
        .wr_data(wr_data), .wr_valid(wr_valid), .wr_ready(wr_ready),
        .rd_data(rd_data), .rd_valid(rd_valid), .rd_ready(rd_ready),
        .done(done), .spi_cs_n(spi_cs_n), .spi_sck(spi_sck),
        .spi_io_o(spi_io_o), .spi_io_oe(spi_io_oe), .spi_io_i(spi_io_i)
    );

    int checks = 0, fails = 0;
    int ncyc = 0;
    bit wd_hit = 0;

    // transaction under test
    logic [7:0]  t_opc;
    logic [23:0] t_addr;
    int t_ab, t_dm, t_len, t_seed;
    bit t_rd, t_quad;
    logic [7:0] wbuf [0:15];
    logic [7:0] rd_got [0:15];
    int wr_idx = 0, wlen = 0, rd_cnt = 0;
    logic wr_hs = 1'b0, rd_hs = 1'b0;
    logic [7:0] rd_cap = '0;

    // serial-side log
    logic [7:0] lg [0:511];
    int rises = 0;
    int r2_bad = 0;

    bit done_seen = 0;
    bit prev_cs = 1, prev_done = 0, have_rise = 0;
    int rise_cyc = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] dev_byte(input int k);
        return 8'((k * 59 + t_seed) ^ 8'hA5);
    endfunction

    function automatic logic [3:0] dev_drive(input int idx);
        int base;
        int j;
        logic [7:0] b;
        base = 8 + 8 * t_ab + t_dm;
        j = idx - base;
        if (!t_rd || j < 0 || j >= t_len * (t_quad ? 2 : 8)) return 4'b0000;
        if (t_quad) begin
            b = dev_byte(j / 2);
            return (j % 2 == 0) ? b[7:4] : b[3:0];
        end
        b = dev_byte(j / 8);
        return {2'b00, b[7 - (j % 8)], 1'b0};
    endfunction

    assign spi_io_i = dev_drive(rises);

    // expected {oe, io} for serial clock i
    function automatic logic [7:0] exp_clk(input int i);
        int bd, bx, j;
        logic [7:0] b;
        bd = 8 + 8 * t_ab;
        bx = bd + t_dm;
        if (i < 8) return {4'b0001, 3'b000, t_opc[7 - i]};
        if (i < bd) return {4'b0001, 3'b000, 1'((t_addr >> (8 * t_ab - 1 - (i - 8))) & 24'd1)};
        if (i < bx) return 8'h10;
        j = i - bx;
        if (t_rd) return 8'h00;
        if (t_quad) begin
            b = wbuf[j / 2];
            return {4'b1111, (j % 2 == 0) ? b[7:4] : b[3:0]};
        end
        b = wbuf[j / 8];
        return {4'b0001, 3'b000, b[7 - (j % 8)]};
    endfunction

    // serial monitor
    always @(negedge spi_cs_n) rises = 0;
    always @(posedge spi_sck) begin
        if (spi_cs_n) r2_bad++;
        if (rises < 512) lg[rises] = {spi_io_oe, spi_io_o};
        rises++;
    end

    // handshake capture at the edge
    always @(posedge clk) begin
        ncyc++;
        wr_hs  <= wr_valid && wr_ready;
        rd_hs  <= rd_valid && rd_ready;
        rd_cap <= rd_data;
    end

    // stream drivers, done monitor, watchdog
    always @(negedge clk) begin
        if (wr_hs) wr_idx++;
        wr_valid = (wr_idx < wlen) && ($urandom % 5 != 0);
        wr_data  = (wr_idx < 16) ? wbuf[wr_idx] : 8'h00;
        if (rd_hs && rd_cnt < 16) begin
            rd_got[rd_cnt] = rd_cap;
            rd_cnt++;
        end
        rd_ready = ($urandom % 3 != 0);

        if (rst_n) begin
            if (!prev_cs && spi_cs_n) begin
                rise_cyc = ncyc;
                have_rise = 1;
            end
            if (prev_cs && !spi_cs_n && have_rise)
                chk(ncyc - rise_cyc > 2 * SCK_DIV, "R9 deselect time", ncyc - rise_cyc, 2 * SCK_DIV + 1);
            if (done) begin
                chk(ncyc == rise_cyc + 1, "R9 done timing", ncyc, rise_cyc + 1);
                chk(!prev_done, "R9 done width", 2, 1);
                done_seen = 1;
            end
            prev_cs = spi_cs_n;
            prev_done = done;
        end

        if (ncyc > 150000 && !wd_hit) begin
            wd_hit = 1;
            checks++;
            fails++;
            $display("FAIL R8 watchdog actual=%0d expected=%0d", ncyc, 150000);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic run_txn(input logic [7:0] opc, input logic [23:0] addr, input int ab,
                           input int dm, input bit rd, input int len, input bit quad);
        int bad3, bad4, bad5, badd, guard, nclk, expclk, ph;
        logic [7:0] g, e;
        t_opc = opc; t_addr = addr & ((24'd1 << (8 * ab)) - 24'd1);
        t_ab = ab; t_dm = dm; t_rd = rd; t_len = len; t_quad = quad;
        t_seed = int'($urandom % 256);
        for (int k = 0; k < 16; k++) wbuf[k] = 8'($urandom);
        @(negedge clk);
        wr_idx = 0; wlen = rd ? 0 : len; rd_cnt = 0; done_seen = 0;
        req_opcode = opc; req_addr = addr; req_addr_bytes = 2'(ab);
        req_dummy = 4'(dm); req_read = rd; req_len = 12'(len); req_quad = quad;
        req_valid = 1'b1;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        chk(!req_ready && !spi_cs_n, "R1 accept", {req_ready, spi_cs_n}, 0);
        guard = 0;
        while (!done_seen && guard < 5000) begin @(negedge clk); guard++; end
        guard = 0;
        while (rd && rd_cnt < len && guard < 500) begin @(negedge clk); guard++; end

        nclk = rises;
        expclk = 8 + 8 * ab + dm + len * (quad ? 2 : 8);
        chk(nclk == expclk, "R8 clock count", nclk, expclk);
        bad3 = 0; bad4 = 0; bad5 = 0; badd = 0;
        for (int i = 0; i < nclk && i < expclk && i < 512; i++) begin
            g = lg[i];
            e = exp_clk(i);
            ph = (i < 8) ? 3 : (i < 8 + 8 * ab) ? 4 : (i < 8 + 8 * ab + dm) ? 5 : 6;
            if (g[7:4] != e[7:4] || ((g[3:0] & e[7:4]) != (e[3:0] & e[7:4]))) begin
                if (ph == 3) bad3++;
                else if (ph == 4) bad4++;
                else if (ph == 5) bad5++;
                else badd++;
            end
        end
        chk(bad3 == 0, "R3 opcode bits", bad3, 0);
        if (ab > 0) chk(bad4 == 0, "R4 address bits", bad4, 0);
        if (dm > 0) chk(bad5 == 0, "R5 dummy clocks", bad5, 0);
        if (len > 0) begin
            if (quad) chk(badd == 0, "R7 four-lane data clocks", badd, 0);
            else      chk(badd == 0, "R6 one-lane data clocks", badd, 0);
            if (rd) begin
                chk(rd_cnt == len, "R10 read bytes delivered", rd_cnt, len);
                for (int k = 0; k < len && k < rd_cnt; k++) begin
                    if (quad) chk(rd_got[k] == dev_byte(k), "R7 read byte", rd_got[k], dev_byte(k));
                    else      chk(rd_got[k] == dev_byte(k), "R6 read byte", rd_got[k], dev_byte(k));
                end
            end else begin
                chk(wr_idx == len, "R10 write bytes consumed", wr_idx, len);
            end
        end
        chk(r2_bad == 0, "R2 rise outside frame", r2_bad, 0);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        chk(spi_cs_n === 1'b1 && spi_sck === 1'b0 && spi_io_oe === 4'b0000 &&
            done === 1'b0 && rd_valid === 1'b0, "R11 reset outputs",
            {spi_cs_n, spi_sck, spi_io_oe, done, rd_valid}, 8'b1000_0000 >> 0 == 0 ? 0 : 32'h80 >> 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // directed corners
        run_txn(8'hFF, 24'h0, 0, 0, 1'b0, 0, 1'b0);          // opcode only
        run_txn(8'h06, 24'h0, 0, 0, 1'b0, 0, 1'b0);
        run_txn(8'h0F, 24'hC0, 1, 0, 1'b1, 1, 1'b0);         // register read
        run_txn(8'h1F, 24'hA0, 1, 0, 1'b0, 1, 1'b0);         // register write
        run_txn(8'h9F, 24'h00, 1, 0, 1'b1, 2, 1'b0);         // identification
        run_txn(8'h13, 24'h01_23_45, 3, 0, 1'b0, 0, 1'b0);   // row address only
        run_txn(8'h0B, 24'h0_07FF, 2, 8, 1'b1, 5, 1'b0);     // one-lane cache read
        run_txn(8'h6B, 24'h0_0010, 2, 8, 1'b1, 6, 1'b1);     // four-lane cache read
        run_txn(8'h32, 24'h0_0000, 2, 0, 1'b0, 7, 1'b1);     // four-lane load
        run_txn(8'h02, 24'h0_0800, 2, 0, 1'b0, 4, 1'b0);     // one-lane load
        run_txn(8'hA5, 24'h0, 0, 15, 1'b1, 3, 1'b1);         // dummy then data, no address

        for (int n = 0; n < 40; n++) begin
            run_txn(8'($urandom), 24'($urandom), int'($urandom % 4), int'($urandom % 16),
                    1'($urandom), int'($urandom % 11), 1'($urandom));
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule